// File: doc/BRIEF.md
# Two-Port RAM Wrapper with Selectable Control Polarities

This block is a parameterized memory with one write port and one read port, both the same width. It runs from one clock shared by both ports, or from separate write and read clocks. Each clock can use its rising or its falling edge. The array read is synchronous: the read port registers the addressed word on its active edge.

The write enable and the read enable can each be an active-low pin, an active-high pin, or tied off so that the enable is always on. The write port can optionally apply byte-lane enables. The read data can come straight from the array's read register (bypass), or pass through one more output register (pipelined). That output register has its own load enable, synchronous clear and asynchronous clear. Each of the three is an active-low pin, an active-high pin, or tied off.

Pins that a configuration does not use stay in the port list and are ignored.

Top module: `tpram_top`

## Requirements
- R1: With `WE_POL` 0 a word is written when `wen_i` is low at the active write edge, with 1 when it is high, and with 2 on every active write edge whatever `wen_i` carries.
- R2: The byte-lane width is 9 when `DATA_W` is a multiple of 9 and 8 otherwise. `BE_W` is `DATA_W` divided by that lane width, rounded up. With `BYTE_EN`=1, bit k of `wbe_i` gates data bits from k*lane upward, so for 18-bit data bit 0 covers bits 8:0 and bit 1 covers bits 17:9. With `BYTE_EN`=0, `wbe_i` is ignored.
- R3: In bypass mode (`RD_PIPE`=0) the addressed word appears on `rdata_o` after one enabled read edge. In pipelined mode (`RD_PIPE`=1) it appears after two enabled read edges, and after the first edge `rdata_o` still shows the earlier word.
- R4: With a shared clock, a read and a write to the same address on the same edge return the word stored before that write.
- R5: With `CLK_MODE`=1 both ports use `wclk_i` and `rclk_i` is ignored. With `CLK_MODE`=2 the read port uses `rclk_i`.
- R6: An edge parameter of 0 selects the rising edge and 1 selects the falling edge (`WR_EDGE` for the write clock, `RD_EDGE` for the read clock). `rdata_o` changes only on the selected edge.
- R7: The read enable follows the same 0/1/2 polarity coding as R1. When it is inactive, neither the array read register nor the output register changes.
- R8: The output-register load enable follows the 0/1/2 coding (2 = always on). When it is inactive the register holds, even on an enabled read.
- R9: The synchronous clear follows the 0/1/2 coding (2 = never). On an active read edge it sets the output register to zero, ahead of the load enable and the read enable.
- R10: The asynchronous clear follows the 0/1/2 coding (2 = never). It sets the output register to zero at once, without a clock edge, and holds it at zero ahead of every other control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock; shared clock when `CLK_MODE`=1 |
| rclk_i | input | 1 | Read clock when `CLK_MODE`=2 |
| wen_i | input | 1 | Write enable, polarity set by `WE_POL` |
| waddr_i | input | AW | Write address |
| wdata_i | input | DATA_W | Write data |
| wbe_i | input | BE_W | Byte-lane write enables, used when `BYTE_EN`=1 |
| ren_i | input | 1 | Read enable, polarity set by `RE_POL` |
| raddr_i | input | AW | Read address |
| oen_i | input | 1 | Output-register load enable, polarity set by `OEN_POL` |
| osrst_i | input | 1 | Output-register synchronous clear, polarity set by `OSRST_POL` |
| oarst_i | input | 1 | Output-register asynchronous clear, polarity set by `OARST_POL` |
| rdata_o | output | DATA_W | Read data |

## Verification
The bench builds two instances. The first has 18-bit data, one rising-edge clock, an active-high write enable and an active-low read enable. It uses the pipelined output with an active-high load enable, an active-high synchronous clear and an active-low asynchronous clear, and it has byte lanes. This instance covers 9-bit lane masking, read-during-write on one clock, the two-edge latency, the hold behaviour and the priority of the clears.

The second instance has 16-bit data, separate clocks with the read port on the falling edge, and bypass mode. Its write and read enables are tied off. It shows that reads follow the falling edge of the independent read clock and that the enable pins are ignored when tied.

// File: rtl/tpram_pkg.sv
package tpram_pkg;

    // Polarity codes shared by every control pin
    localparam int POL_LOW  = 0;
    localparam int POL_HIGH = 1;
    localparam int POL_TIE  = 2;

    function automatic int lane_width(input int w);
        return ((w % 9) == 0) ? 9 : 8;
    endfunction

    function automatic int lane_count(input int w);
        return (w + lane_width(w) - 1) / lane_width(w);
    endfunction

endpackage

// File: rtl/tpram_pol.sv
module tpram_pol #(
    parameter int POL = 1,
    parameter bit TIE = 1'b1
) (
    input  logic pin_i,
    output logic act_o
);
    if (POL == tpram_pkg::POL_LOW) begin : g_low
        assign act_o = ~pin_i;
    end else if (POL == tpram_pkg::POL_HIGH) begin : g_high
        assign act_o = pin_i;
    end else begin : g_tie
        logic unused_pin;
        assign unused_pin = pin_i;
        assign act_o      = TIE;
    end
endmodule

// File: rtl/tpram_array.sv
module tpram_array #(
    parameter int DATA_W  = 18,
    parameter int DEPTH   = 1024,
    parameter int AW      = 10,
    parameter int BE_W    = 2,
    parameter int LANE_W  = 9,
    parameter bit BYTE_EN = 1'b0
) (
    input  logic              wclk_i,
    input  logic              we_i,
    input  logic [AW-1:0]     waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [BE_W-1:0]   wbe_i,
    input  logic              rclk_i,
    input  logic              re_i,
    input  logic [AW-1:0]     raddr_i,
    output logic [DATA_W-1:0] rdata_q
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] bit_mask;

    // Expand the lane enables into a per-bit write mask
    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            bit_mask[i] = BYTE_EN ? wbe_i[i / LANE_W] : 1'b1;
        end
    end

    always_ff @(posedge wclk_i) begin
        if (we_i) begin
            mem[waddr_i] <= (mem[waddr_i] & ~bit_mask) | (wdata_i & bit_mask);
        end
    end

    // Nonblocking read: on a shared clock a same-address write is not yet visible
    always_ff @(posedge rclk_i) begin
        if (re_i) begin
            rdata_q <= mem[raddr_i];
        end
    end
endmodule

// File: rtl/tpram_oreg.sv
module tpram_oreg #(
    parameter int DATA_W = 18
) (
    input  logic              clk_i,
    input  logic              arst_i,
    input  logic              srst_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] d_i,
    output logic [DATA_W-1:0] q_o
);
    // Priority: async clear, then sync clear, then load
    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) begin
            q_o <= '0;
        end else if (srst_i) begin
            q_o <= '0;
        end else if (load_i) begin
            q_o <= d_i;
        end
    end
endmodule

// File: rtl/tpram_top.sv
module tpram_top #(
    parameter int DATA_W    = 18,
    parameter int DEPTH     = 1024,
    parameter int CLK_MODE  = 1,
    parameter bit WR_EDGE   = 1'b0,
    parameter bit RD_EDGE   = 1'b0,
    parameter int WE_POL    = 1,
    parameter int RE_POL    = 2,
    parameter bit RD_PIPE   = 1'b0,
    parameter int OEN_POL   = 2,
    parameter int OSRST_POL = 2,
    parameter int OARST_POL = 2,
    parameter bit BYTE_EN   = 1'b0,
    localparam int AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LANE_W   = tpram_pkg::lane_width(DATA_W),
    localparam int BE_W     = tpram_pkg::lane_count(DATA_W)
) (
    input  logic              wclk_i,
    input  logic              rclk_i,
    input  logic              wen_i,
    input  logic [AW-1:0]     waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [BE_W-1:0]   wbe_i,
    input  logic              ren_i,
    input  logic [AW-1:0]     raddr_i,
    input  logic              oen_i,
    input  logic              osrst_i,
    input  logic              oarst_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic wclk_int;
    logic rclk_int;
    logic we_act;
    logic ren_act;
    logic oen_act;
    logic srst_act;
    logic arst_act;
    logic [DATA_W-1:0] arr_q;

    // Clock selection and edge choice
    assign wclk_int = WR_EDGE ? ~wclk_i : wclk_i;

    if (CLK_MODE == 1) begin : g_shared_clk
        logic unused_rclk;
        assign unused_rclk = rclk_i;
        assign rclk_int    = wclk_int;
    end else begin : g_split_clk
        assign rclk_int = RD_EDGE ? ~rclk_i : rclk_i;
    end

    // Control pin polarity resolution
    tpram_pol #(.POL(WE_POL),    .TIE(1'b1)) u_we_pol   (.pin_i(wen_i),   .act_o(we_act));
    tpram_pol #(.POL(RE_POL),    .TIE(1'b1)) u_re_pol   (.pin_i(ren_i),   .act_o(ren_act));
    tpram_pol #(.POL(OEN_POL),   .TIE(1'b1)) u_oen_pol  (.pin_i(oen_i),   .act_o(oen_act));
    tpram_pol #(.POL(OSRST_POL), .TIE(1'b0)) u_srst_pol (.pin_i(osrst_i), .act_o(srst_act));
    tpram_pol #(.POL(OARST_POL), .TIE(1'b0)) u_arst_pol (.pin_i(oarst_i), .act_o(arst_act));

    tpram_array #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH),
        .AW     (AW),
        .BE_W   (BE_W),
        .LANE_W (LANE_W),
        .BYTE_EN(BYTE_EN)
    ) u_array (
        .wclk_i (wclk_int),
        .we_i   (we_act),
        .waddr_i(waddr_i),
        .wdata_i(wdata_i),
        .wbe_i  (wbe_i),
        .rclk_i (rclk_int),
        .re_i   (ren_act),
        .raddr_i(raddr_i),
        .rdata_q(arr_q)
    );

    if (RD_PIPE) begin : g_pipe
        tpram_oreg #(.DATA_W(DATA_W)) u_oreg (
            .clk_i (rclk_int),
            .arst_i(arst_act),
            .srst_i(srst_act),
            .load_i(oen_act & ren_act),
            .d_i   (arr_q),
            .q_o   (rdata_o)
        );
    end else begin : g_bypass
        logic unused_ctl;
        assign unused_ctl = oen_act ^ srst_act ^ arst_act;
        assign rdata_o    = arr_q;
    end
endmodule

// File: rtl/tpram_chk.sv
module tpram_chk #(
    parameter bit PIPE   = 1'b0,
    parameter int DATA_W = 18
) (
    input logic              rclk,
    input logic              ren_act,
    input logic              oen_act,
    input logic              srst_act,
    input logic              arst_act,
    input logic [DATA_W-1:0] arr_q,
    input logic [DATA_W-1:0] rdata
);
    logic primed = 1'b0;
    always_ff @(posedge rclk) primed <= 1'b1;

    // R3, R8: an enabled load moves the array word into the output register
    assert_pipe_load_R3: assert property (@(posedge rclk) disable iff (arst_act)
        primed && PIPE && ren_act && oen_act && !srst_act |=> rdata == $past(arr_q));

    // R7, R8: the output does not move while the read port is idle
    assert_idle_hold_R7: assert property (@(posedge rclk) disable iff (arst_act)
        primed && !ren_act && !srst_act |=> $stable(rdata));

    // R8: a disabled output register holds its value
    assert_oen_hold_R8: assert property (@(posedge rclk) disable iff (arst_act)
        primed && PIPE && !oen_act && !srst_act |=> $stable(rdata));

    // R9: the sync clear wins over every enable
    assert_sync_clear_R9: assert property (@(posedge rclk) disable iff (arst_act)
        primed && PIPE && srst_act |=> rdata == '0);

    // R10: an async clear held across an edge keeps the output at zero
    assert_async_clear_R10: assert property (@(posedge rclk)
        primed && PIPE && arst_act && $past(arst_act) |-> rdata == '0);
endmodule

bind tpram_top tpram_chk #(.PIPE(RD_PIPE), .DATA_W(DATA_W)) u_chk (
    .rclk    (rclk_int),
    .ren_act (ren_act),
    .oen_act (oen_act),
    .srst_act(srst_act),
    .arst_act(arst_act),
    .arr_q   (arr_q),
    .rdata   (rdata_o)
);

// File: tb/sim_tpram_top.sv
`timescale 1ns/1ps
module sim_tpram_top;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic clk  = 1'b0;
    logic rclk = 1'b0;
    always #5 clk  = ~clk;
    always #7 rclk = ~rclk;

    // Instance u0: shared rising clock, pipelined output, byte lanes
    logic        w0_we = 1'b0;
    logic [9:0]  w0_addr = '0;
    logic [17:0] w0_data = '0;
    logic [1:0]  w0_be = 2'b11;
    logic        r0_ren_n = 1'b1;
    logic [9:0]  r0_addr = '0;
    logic        r0_oen = 1'b1;
    logic        r0_srst = 1'b0;
    logic        r0_arst_n = 1'b0;
    logic [17:0] r0_data;

    tpram_top #(
        .DATA_W(18), .DEPTH(1024), .CLK_MODE(1), .WR_EDGE(1'b0),
        .WE_POL(1), .RE_POL(0), .RD_PIPE(1'b1),
        .OEN_POL(1), .OSRST_POL(1), .OARST_POL(0), .BYTE_EN(1'b1)
    ) u0 (
        .wclk_i(clk), .rclk_i(1'b0), .wen_i(w0_we), .waddr_i(w0_addr),
        .wdata_i(w0_data), .wbe_i(w0_be), .ren_i(r0_ren_n), .raddr_i(r0_addr),
        .oen_i(r0_oen), .osrst_i(r0_srst), .oarst_i(r0_arst_n), .rdata_o(r0_data)
    );

    // Instance u1: split clocks, falling read edge, bypass, tied enables
    logic        w1_en = 1'b0;
    logic [5:0]  w1_addr = 6'd9;
    logic [15:0] w1_data = '0;
    logic [5:0]  r1_addr = 6'd9;
    logic        r1_en = 1'b0;
    logic [15:0] r1_data;

    tpram_top #(
        .DATA_W(16), .DEPTH(64), .CLK_MODE(2), .WR_EDGE(1'b0), .RD_EDGE(1'b1),
        .WE_POL(2), .RE_POL(2), .RD_PIPE(1'b0), .BYTE_EN(1'b0)
    ) u1 (
        .wclk_i(clk), .rclk_i(rclk), .wen_i(w1_en), .waddr_i(w1_addr),
        .wdata_i(w1_data), .wbe_i(2'b00), .ren_i(r1_en), .raddr_i(r1_addr),
        .oen_i(1'b0), .osrst_i(1'b1), .oarst_i(1'b1), .rdata_o(r1_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr0(input logic [9:0] a, input logic [17:0] d, input logic [1:0] be);
        @(negedge clk);
        w0_we = 1'b1; w0_addr = a; w0_data = d; w0_be = be;
        @(negedge clk);
        w0_we = 1'b0; w0_be = 2'b11;
    endtask

    // Two enabled read edges, sampled at the following falling edge
    task automatic rd0(input logic [9:0] a, output logic [17:0] d);
        @(negedge clk);
        r0_addr = a; r0_ren_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        d = r0_data;
        r0_ren_n = 1'b1;
    endtask

    task automatic t_reset;
        #1;
        chk("R10 reset state", 32'(r0_data), 32'h0);
        @(negedge clk);
        r0_arst_n = 1'b1;
    endtask

    task automatic t_write_read;
        logic [17:0] d;
        wr0(10'd1, 18'h12345, 2'b11);
        wr0(10'd2, 18'h0BEEF, 2'b11);
        wr0(10'd3, 18'h3C0F0, 2'b11);
        rd0(10'd1, d); chk("R1 read addr1", 32'(d), 32'h12345);
        rd0(10'd3, d); chk("R1 read addr3", 32'(d), 32'h3C0F0);
        // R3 latency: one edge later still old word, two edges later new word
        @(negedge clk);
        r0_addr = 10'd2; r0_ren_n = 1'b0;
        @(negedge clk);
        chk("R3 pipe after one edge", 32'(r0_data), 32'h3C0F0);
        @(negedge clk);
        chk("R3 pipe after two edges", 32'(r0_data), 32'h0BEEF);
        r0_ren_n = 1'b1;
    endtask

    task automatic t_we_inactive;
        logic [17:0] d;
        @(negedge clk);
        w0_we = 1'b0; w0_addr = 10'd1; w0_data = 18'h00000;
        @(negedge clk);
        rd0(10'd1, d); chk("R1 write enable low", 32'(d), 32'h12345);
    endtask

    task automatic t_bytes;
        logic [17:0] d;
        wr0(10'd7, 18'h00000, 2'b11);
        wr0(10'd7, 18'h3FFFF, 2'b01);
        rd0(10'd7, d); chk("R2 lane0 only", 32'(d), 32'h001FF);
        wr0(10'd8, 18'h3FFFF, 2'b11);
        wr0(10'd8, 18'h00000, 2'b10);
        rd0(10'd8, d); chk("R2 lane1 cleared", 32'(d), 32'h001FF);
    endtask

    task automatic t_collide;
        logic [17:0] d;
        wr0(10'd20, 18'h2AAAA, 2'b11);
        @(negedge clk);
        w0_we = 1'b1; w0_addr = 10'd20; w0_data = 18'h15555;
        r0_addr = 10'd20; r0_ren_n = 1'b0;
        @(negedge clk);
        w0_we = 1'b0;
        @(negedge clk);
        chk("R4 read returns old word", 32'(r0_data), 32'h2AAAA);
        @(negedge clk);
        chk("R4 next read returns new word", 32'(r0_data), 32'h15555);
        r0_ren_n = 1'b1;
        rd0(10'd20, d); chk("R4 stored word", 32'(d), 32'h15555);
    endtask

    task automatic t_ren_off;
        logic [17:0] d;
        rd0(10'd1, d);
        @(negedge clk);
        r0_addr = 10'd2; r0_ren_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R7 output holds while idle", 32'(r0_data), 32'h12345);
        r0_ren_n = 1'b0;
        @(negedge clk);
        chk("R7 array register held", 32'(r0_data), 32'h12345);
        @(negedge clk);
        chk("R7 resumes", 32'(r0_data), 32'h0BEEF);
        r0_ren_n = 1'b1;
    endtask

    task automatic t_oen;
        logic [17:0] d;
        rd0(10'd1, d);
        @(negedge clk);
        r0_oen = 1'b0;
        rd0(10'd3, d); chk("R8 load enable off holds", 32'(d), 32'h12345);
        r0_oen = 1'b1;
        @(negedge clk);
        r0_ren_n = 1'b0;
        @(negedge clk);
        chk("R8 load enable on", 32'(r0_data), 32'h3C0F0);
        r0_ren_n = 1'b1;
    endtask

    task automatic t_srst;
        logic [17:0] d;
        rd0(10'd1, d);
        @(negedge clk);
        r0_srst = 1'b1; r0_oen = 1'b1; r0_ren_n = 1'b0; r0_addr = 10'd1;
        @(negedge clk);
        chk("R9 sync clear wins", 32'(r0_data), 32'h0);
        r0_ren_n = 1'b1;
        @(negedge clk);
        chk("R9 sync clear with read idle", 32'(r0_data), 32'h0);
        r0_srst = 1'b0;
    endtask

    task automatic t_arst;
        logic [17:0] d;
        rd0(10'd3, d);
        @(negedge clk);
        #2;
        r0_arst_n = 1'b0;
        #1;
        chk("R10 immediate clear", 32'(r0_data), 32'h0);
        r0_ren_n = 1'b0; r0_addr = 10'd3;
        @(negedge clk);
        @(negedge clk);
        chk("R10 clear over enables", 32'(r0_data), 32'h0);
        r0_arst_n = 1'b1; r0_ren_n = 1'b1;
    endtask

    task automatic t_split;
        @(negedge clk);
        w1_en = 1'b0; w1_addr = 6'd5; w1_data = 16'hBEEF;
        @(negedge clk);
        @(negedge clk);
        w1_addr = 6'd6; w1_data = 16'h1234;
        @(negedge clk);
        @(negedge clk);
        w1_addr = 6'd9; w1_data = 16'h0000;
        @(negedge rclk);
        r1_addr = 6'd5; r1_en = 1'b0;
        @(negedge rclk);
        @(negedge rclk);
        #1;
        chk("R1 R7 tied enables", 32'(r1_data), 32'h0000BEEF);
        r1_addr = 6'd6;
        @(posedge rclk);
        #1;
        chk("R6 no change on rising edge", 32'(r1_data), 32'h0000BEEF);
        @(negedge rclk);
        #1;
        chk("R5 R3 bypass on falling read edge", 32'(r1_data), 32'h00001234);
    endtask

    initial begin
        t_reset();
        t_write_read();
        t_we_inactive();
        t_bytes();
        t_collide();
        t_ren_off();
        t_oen();
        t_srst();
        t_arst();
        t_split();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule